// File: doc/BRIEF.md
# Speculative Write-Set Buffer

This block holds the stores a transaction makes while it runs optimistically, before it is allowed to publish them. Each store names a word-aligned address and a data word. The block keeps them in a small fully associative array and writes nothing to shared memory. A repeated store to an address the array already holds replaces the data in that entry. It does not take a second slot.

A transactional load is first compared against every live entry. On a hit, the response carries the buffered word. On a miss, the response reports that the load must go to memory, and the block emits the load address on a read-set insert output. A load that a buffered entry served never appears on the read-set output. An abort clears the buffer in one cycle, and nothing needs to be undone. A commit starts the publish phase. In that phase the entries leave through a valid/ready write-back port, oldest allocation first, and a one-cycle done pulse follows the last entry. Once publishing has begun, it cannot be cancelled.

Top module: `wset_buf`

## Requirements
- R1: After reset all outputs are low and the buffer is empty, so a commit issued straight after reset produces a done pulse and no write-back beat.
- R2: A load whose address matches a live entry gives, one cycle later, ld_hit_o=1 with ld_data_o equal to that entry's latest data, and rs_valid_o=0.
- R3: A load whose address matches no entry gives, one cycle later, ld_hit_o=0 together with rs_valid_o=1 and rs_addr_o equal to the load address.
- R4: A store to an address already held overwrites that entry's data. It allocates no new entry, so the address is written back only once and carries the last data stored.
- R5: A store to a new address takes the next free slot. The write-back port presents entries in the order their addresses were first stored.
- R6: A store to a new address while all DEPTH entries are in use leaves the buffer unchanged and raises ovf_o for exactly the following cycle. A store to an address already held never raises ovf_o, including when the buffer is full.
- R7: An abort issued while not publishing empties the buffer. Every later load misses, the next commit writes back nothing, and the abort itself causes no write-back beat.
- R8: While dr_valid_o is high and dr_ready_i is low, dr_valid_o, dr_addr_o and dr_data_o stay unchanged. Each accepted beat moves to the next entry.
- R9: dr_done_o pulses for one cycle, in the cycle after the last beat is accepted (or in the cycle after a commit to an empty buffer). dr_valid_o is low during the pulse, and the buffer is empty afterwards.
- R10: While publishing, stores, commits and aborts are ignored. A store that arrives in the same cycle as a commit or an abort is also dropped.
- R11: A load and a store in the same cycle: the load sees the buffer contents as they were before that store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid_i | input | 1 | Store request |
| st_addr_i | input | AW | Store word address |
| st_data_i | input | DW | Store data |
| ld_valid_i | input | 1 | Load lookup request |
| ld_addr_i | input | AW | Load word address |
| ld_hit_o | output | 1 | Load was served by the buffer |
| ld_data_o | output | DW | Forwarded data (zero on miss) |
| rs_valid_o | output | 1 | Read-set insert strobe for a missing load |
| rs_addr_o | output | AW | Address to add to the read set |
| commit_i | input | 1 | Start publishing the buffer |
| abort_i | input | 1 | Discard the buffer |
| ovf_o | output | 1 | Capacity overflow pulse |
| dr_valid_o | output | 1 | Write-back beat valid |
| dr_addr_o | output | AW | Write-back address |
| dr_data_o | output | DW | Write-back data |
| dr_ready_i | input | 1 | Write-back beat accepted |
| dr_done_o | output | 1 | Publishing finished |

## Verification
The buffer is filled to every level from empty to full. Each fill is followed by loads that sweep an address range covering both held and absent words, which separates forwarding from read-set insertion at every occupancy. A repeated store to the first slot separates overwrite from allocation, and the write-back order and data show the difference. Stores past capacity, aborts, and a same-cycle store with a load of the same word each check one ordering rule. Publishing runs against several ready patterns, with stray store, commit and abort requests arriving mid-drain, to show that the beats hold steady and that the late requests are ignored.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  // index width that never collapses to zero bits
  function automatic int unsigned idx_w(input int unsigned d);
    return (d > 1) ? $clog2(d) : 1;
  endfunction
endpackage

// File: rtl/wsb_cam.sv
module wsb_cam
  import wsb_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  parameter int IW    = idx_w(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [AW-1:0] waddr,
  input  logic [CW-1:0] count,
  input  logic [AW-1:0] qa_addr,
  output logic          qa_hit,
  output logic [IW-1:0] qa_idx,
  input  logic [AW-1:0] qb_addr,
  output logic          qb_hit,
  output logic [IW-1:0] qb_idx,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_addr
);
  logic [AW-1:0]    tag_q [DEPTH];
  logic [DEPTH-1:0] ma, mb;

  always_ff @(posedge clk) begin
    if (we) tag_q[widx] <= waddr;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic live;
    assign live  = (CW'(g) < count);
    assign ma[g] = live && (tag_q[g] == qa_addr);
    assign mb[g] = live && (tag_q[g] == qb_addr);
  end

  always_comb begin
    qa_idx = '0;
    qb_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ma[i]) qa_idx = IW'(i);
      if (mb[i]) qb_idx = IW'(i);
    end
  end

  assign qa_hit  = |ma;
  assign qb_hit  = |mb;
  assign rd_addr = tag_q[rd_idx];

  // R4
  single_match_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(mb));
endmodule

// File: rtl/wsb_data.sv
module wsb_data
  import wsb_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int IW    = idx_w(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [IW-1:0] rb_idx,
  output logic [DW-1:0] rb_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];
endmodule

// File: rtl/wsb_drain.sv
module wsb_drain
  import wsb_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int IW    = idx_w(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] count,
  output logic [IW-1:0] rd_idx,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  input  logic          ready,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          done_o,
  output logic          busy_o,
  output logic          fin_o
);
  logic [IW-1:0] ptr;
  logic          last;

  assign last   = (CW'(ptr) + CW'(1)) == count;
  assign rd_idx = busy_o ? ptr + IW'(1) : '0;
  assign fin_o  = (busy_o && valid_o && ready && last) || (!busy_o && start && count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o  <= 1'b0;
      valid_o <= 1'b0;
      done_o  <= 1'b0;
      ptr     <= '0;
      addr_o  <= '0;
      data_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start) begin
          if (count == '0) begin
            done_o <= 1'b1;
          end else begin
            busy_o  <= 1'b1;
            valid_o <= 1'b1;
            ptr     <= '0;
            addr_o  <= rd_addr;
            data_o  <= rd_data;
          end
        end
      end else if (valid_o && ready) begin
        if (last) begin
          valid_o <= 1'b0;
          busy_o  <= 1'b0;
          done_o  <= 1'b1;
        end else begin
          ptr    <= ptr + IW'(1);
          addr_o <= rd_addr;
          data_o <= rd_data;
        end
      end
    end
  end

  // R8
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !ready) |=> (valid_o && $stable(addr_o) && $stable(data_o)));
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done_o |-> !valid_o);
endmodule

// File: rtl/wset_buf.sv
module wset_buf
  import wsb_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  input  logic          ld_valid_i,
  input  logic [AW-1:0] ld_addr_i,
  output logic          ld_hit_o,
  output logic [DW-1:0] ld_data_o,
  output logic          rs_valid_o,
  output logic [AW-1:0] rs_addr_o,
  input  logic          commit_i,
  input  logic          abort_i,
  output logic          ovf_o,
  output logic          dr_valid_o,
  output logic [AW-1:0] dr_addr_o,
  output logic [DW-1:0] dr_data_o,
  input  logic          dr_ready_i,
  output logic          dr_done_o
);
  localparam int IW = idx_w(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count;
  logic          busy, fin, start, st_go, room, we;
  logic          ld_hit, st_hit;
  logic [IW-1:0] ld_idx, st_idx, wr_idx, dr_idx;
  logic [AW-1:0] dr_tag;
  logic [DW-1:0] ld_word, dr_word;

  assign start  = commit_i && !busy && !abort_i;
  assign st_go  = st_valid_i && !busy && !commit_i && !abort_i;
  assign room   = count < CW'(DEPTH);
  assign we     = st_go && (st_hit || room);
  assign wr_idx = st_hit ? st_idx : IW'(count);

  wsb_cam #(.AW(AW), .DEPTH(DEPTH), .IW(IW), .CW(CW)) u_cam (
    .clk(clk), .rst(rst), .we(we && !st_hit), .widx(wr_idx), .waddr(st_addr_i),
    .count(count),
    .qa_addr(ld_addr_i), .qa_hit(ld_hit), .qa_idx(ld_idx),
    .qb_addr(st_addr_i), .qb_hit(st_hit), .qb_idx(st_idx),
    .rd_idx(dr_idx), .rd_addr(dr_tag)
  );

  wsb_data #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) u_data (
    .clk(clk), .we(we), .widx(wr_idx), .wdata(st_data_i),
    .ra_idx(ld_idx), .ra_data(ld_word),
    .rb_idx(dr_idx), .rb_data(dr_word)
  );

  wsb_drain #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .IW(IW), .CW(CW)) u_drain (
    .clk(clk), .rst(rst), .start(start), .count(count),
    .rd_idx(dr_idx), .rd_addr(dr_tag), .rd_data(dr_word),
    .ready(dr_ready_i), .valid_o(dr_valid_o), .addr_o(dr_addr_o), .data_o(dr_data_o),
    .done_o(dr_done_o), .busy_o(busy), .fin_o(fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      ovf_o      <= 1'b0;
      ld_hit_o   <= 1'b0;
      ld_data_o  <= '0;
      rs_valid_o <= 1'b0;
      rs_addr_o  <= '0;
    end else begin
      ovf_o <= 1'b0;
      if (abort_i && !busy) begin
        count <= '0;
      end else if (fin) begin
        count <= '0;
      end else if (st_go && !st_hit) begin
        if (room) count <= count + CW'(1);
        else      ovf_o <= 1'b1;
      end
      ld_hit_o   <= ld_valid_i && ld_hit;
      ld_data_o  <= (ld_valid_i && ld_hit) ? ld_word : '0;
      rs_valid_o <= ld_valid_i && !ld_hit;
      rs_addr_o  <= ld_addr_i;
    end
  end

  // R6
  ovf_full_chk: assert property (@(posedge clk) disable iff (rst) ovf_o |-> ($past(count) == CW'(DEPTH)));
  // R5
  occupancy_chk: assert property (@(posedge clk) disable iff (rst) count <= CW'(DEPTH));
  // R3
  load_resp_chk: assert property (@(posedge clk) disable iff (rst) ld_valid_i |=> (ld_hit_o ^ rs_valid_o));
  // R2
  hit_no_rs_chk: assert property (@(posedge clk) disable iff (rst) !(ld_hit_o && rs_valid_o));
endmodule

// File: tb/sim_wset_buf.sv
module sim_wset_buf;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_valid = 0, ld_valid = 0, commit = 0, abort = 0, dr_ready = 0;
  logic [7:0]  st_addr = 0, ld_addr = 0;
  logic [15:0] st_data = 0;
  logic        ld_hit, rs_valid, ovf, dr_valid, dr_done;
  logic [15:0] ld_data, dr_data;
  logic [7:0]  rs_addr, dr_addr;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0]  m_addr [4];
  logic [15:0] m_data [4];
  int m_n = 0;

  always #4 clk = ~clk;

  wset_buf #(.AW(8), .DW(16), .DEPTH(4)) u0 (
    .clk(clk), .rst(rst),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data),
    .ld_valid_i(ld_valid), .ld_addr_i(ld_addr),
    .ld_hit_o(ld_hit), .ld_data_o(ld_data), .rs_valid_o(rs_valid), .rs_addr_o(rs_addr),
    .commit_i(commit), .abort_i(abort), .ovf_o(ovf),
    .dr_valid_o(dr_valid), .dr_addr_o(dr_addr), .dr_data_o(dr_data),
    .dr_ready_i(dr_ready), .dr_done_o(dr_done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int find(input logic [7:0] a);
    for (int i = 0; i < m_n; i++) if (m_addr[i] == a) return i;
    return -1;
  endfunction

  task automatic do_store(input logic [7:0] a, input logic [15:0] d);
    int h = find(a);
    bit e_ovf = 0;
    if (h >= 0) m_data[h] = d;
    else if (m_n < 4) begin m_addr[m_n] = a; m_data[m_n] = d; m_n++; end
    else e_ovf = 1;
    st_valid = 1; st_addr = a; st_data = d;
    @(negedge clk);
    st_valid = 0;
    check(ovf == e_ovf, "R6 ovf", ovf, e_ovf);
  endtask

  task automatic do_load(input logic [7:0] a);
    int h = find(a);
    ld_valid = 1; ld_addr = a;
    @(negedge clk);
    ld_valid = 0;
    if (h >= 0) begin
      check(ld_hit == 1, "R2 hit", ld_hit, 1);
      check(ld_data == m_data[h], "R2 data", ld_data, m_data[h]);
      check(rs_valid == 0, "R2 no read-set", rs_valid, 0);
    end else begin
      check(ld_hit == 0, "R3 miss", ld_hit, 0);
      check(rs_valid == 1, "R3 read-set", rs_valid, 1);
      check(rs_addr == a, "R3 rs addr", rs_addr, a);
    end
  endtask

  task automatic do_abort();
    abort = 1;
    @(negedge clk);
    abort = 0;
    m_n = 0;
    check(dr_valid == 0, "R7 no beat", dr_valid, 0);
  endtask

  task automatic do_commit(input int pat);
    int k = 0, cyc = 0;
    commit = 1;
    @(negedge clk);
    commit = 0;
    while (k < m_n) begin
      bit rdy = ((cyc + pat) % 3) != 0;
      dr_ready = rdy;
      st_valid = (cyc == 1); st_addr = 8'hEE; st_data = 16'hBEEF;
      abort = (cyc == 1); commit = (cyc == 1);
      check(dr_valid == 1, "R8 valid", dr_valid, 1);
      check(dr_addr == m_addr[k], "R5 order", dr_addr, m_addr[k]);
      check(dr_data == m_data[k], "R4 data", dr_data, m_data[k]);
      check(dr_done == 0, "R9 early done", dr_done, 0);
      @(negedge clk);
      cyc++;
      if (rdy) k++;
    end
    dr_ready = 0; st_valid = 0; abort = 0; commit = 0;
    check(dr_done == 1, "R9 done", dr_done, 1);
    check(dr_valid == 0, "R9 idle", dr_valid, 0);
    m_n = 0;
    @(negedge clk);
    check(dr_done == 0, "R9 pulse", dr_done, 0);
    check(dr_valid == 0, "R10 no restart", dr_valid, 0);
    do_load(8'hEE);  // R10: mid-drain store was dropped
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    check(ld_hit == 0 && rs_valid == 0, "R1 load outs", {ld_hit, rs_valid}, 0);
    check(dr_valid == 0 && dr_done == 0 && ovf == 0, "R1 drain outs", {dr_valid, dr_done, ovf}, 0);
    do_commit(0);  // R1: empty after reset

    for (int n = 0; n <= 4; n++) begin
      for (int i = 0; i < n; i++) do_store(8'h10 + 8'(3 * i + n), 16'(i * 16'h111 + n * 7));
      if (n > 0) do_store(8'h10 + 8'(n), 16'hA000 + 16'(n));  // R4 overwrite slot 0
      for (int a = 8'h10; a < 8'h20; a++) do_load(8'(a));
      do_commit(n % 3);
    end

    // R6: overflow then merge when full
    for (int i = 0; i < 4; i++) do_store(8'h30 + 8'(i), 16'(16'h500 + i));
    do_store(8'h3F, 16'h1234);
    do_store(8'h32, 16'h4321);
    for (int a = 8'h30; a < 8'h40; a++) do_load(8'(a));
    do_commit(1);

    // R7: abort discards everything
    for (int i = 0; i < 3; i++) do_store(8'h50 + 8'(i), 16'(16'h700 + i));
    do_abort();
    for (int a = 8'h50; a < 8'h54; a++) do_load(8'(a));
    do_commit(0);

    // R11: same-cycle load and store
    do_store(8'h40, 16'hAAAA);
    st_valid = 1; st_addr = 8'h40; st_data = 16'hBBBB;
    ld_valid = 1; ld_addr = 8'h40;
    @(negedge clk);
    st_valid = 0; ld_valid = 0;
    check(ld_hit == 1 && ld_data == 16'hAAAA, "R11 old data", ld_data, 16'hAAAA);
    m_data[0] = 16'hBBBB;
    st_valid = 1; st_addr = 8'h41; st_data = 16'hCCCC;
    ld_valid = 1; ld_addr = 8'h41;
    @(negedge clk);
    st_valid = 0; ld_valid = 0;
    check(ld_hit == 0 && rs_valid == 1, "R11 new miss", {ld_hit, rs_valid}, 1);
    m_addr[1] = 8'h41; m_data[1] = 16'hCCCC; m_n = 2;
    do_load(8'h40);
    do_load(8'h41);
    do_commit(2);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule